// File: doc/BRIEF.md
# Way-Lockable Set-Associative Instruction Cache Controller

This block holds the tag, valid and replacement control for a read-only, highly associative instruction cache, together with a plain storage array for the cached lines. A fetch address is split into a tag, a set index and a word offset. The tag is compared against every way of the indexed set. On a hit, the requested word is returned after its stored parity bit has been checked. On a miss, a one-cycle line request goes out naming the line address and the chosen victim way. The returned words are written into that way, and the line becomes valid once its last word has arrived. The lookup is then repeated, so the response always comes from the cache.

Software can pin the low-numbered ways of any set by giving that set a lock count. Replacement then rotates only through the ways above the count. A global invalidate drops every unlocked line and leaves locked content and lock counts untouched. A parity mismatch on a hit is handled like a miss into the same way, and an error pulse is raised.

Top module: `wlc_cache`

## Requirements
- R1: The address is decoded as tag = bits [31:10], set = bits [9:5] and word offset = bits [4:2]. A hit returns the word stored at that offset of the matching line. An address that differs from a cached line only in its tag misses.
- R2: After reset every line is invalid, every lock count is 0 and every replacement pointer is 0. `req_ready` is 1, and `resp_valid`, `fill_req` and `par_err` are 0.
- R3: A miss raises `fill_req` for exactly one cycle, with `fill_addr` set to the request address with bits [4:0] cleared and `fill_way` set to the victim way.
- R4: A fill takes eight beats qualified by `fill_valid`; idle cycles between beats are waited through. Beat k is stored as word k. No response is given before the eighth beat, and the response that follows carries the requested word.
- R5: A hit raises no `fill_req` and raises `resp_valid` two cycles after the request is accepted.
- R6: With lock count L in a set, successive victims in that set are L, L+1, ... 31 and then wrap to L. A stale pointer below L is raised to L.
- R7: A written lock count above 28 is stored as 28.
- R8: Parity is even: the stored bit `fill_par` must equal the XOR of the 32 data bits. A mismatch on a hit raises `par_err` together with `fill_req` for the same way, and the refetched word is then returned. The round-robin pointer does not move.
- R9: `inval_all`, taken while idle, clears the valid bit of every way at or above its set's lock count. Locked lines stay valid, and lock counts and pointers are unchanged.
- R10: Requests are accepted only while `req_ready` is 1, which holds only in the idle state. A `req_valid` seen while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request strobe |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| resp_valid | output | 1 | Response word valid (one cycle) |
| resp_data | output | 32 | Fetched word |
| fill_req | output | 1 | Line request pulse |
| fill_addr | output | 32 | Line-aligned address of the request |
| fill_way | output | 5 | Victim way receiving the line |
| fill_valid | input | 1 | Fill beat strobe |
| fill_data | input | 32 | Fill beat word |
| fill_par | input | 1 | Even-parity bit of the fill beat |
| par_err | output | 1 | Parity mismatch on a hit (one cycle) |
| lock_we | input | 1 | Write a set's lock count |
| lock_set | input | 5 | Set whose lock count is written |
| lock_count | input | 5 | New lock count (saturated to 28) |
| inval_all | input | 1 | Invalidate all unlocked lines |

## Verification
The hardest situation to reach is a parity error on a hit. The array never corrupts itself, so the bench injects a bad parity bit on one beat of an otherwise good fill. It first reads a different word of that line, so the line hits cleanly, and only then fetches the corrupted word. It then checks the error pulse, the refill into the same way and the corrected data. The round-robin wrap over unlocked ways also needs long runs of distinct tags in one set. The bench reaches it by issuing 29 and then 5 consecutive misses after setting a lock count.

// File: rtl/wlc_pkg.sv
// Package: shared controller state encoding for the way-lockable cache.
// Assumes: nothing beyond IEEE 1800-2017.
package wlc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_FILL = 2'd2
    } wlc_state_e;
endpackage

// File: rtl/wlc_victim.sv
// Module: per-set lock counts and round-robin pointers; picks the victim way.
// Assumes: MAX_LOCK < WAYS, so a way index width holds any lock count.
module wlc_victim #(
    parameter int SETS     = 32,
    parameter int WAYS     = 32,
    parameter int MAX_LOCK = 28,
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lock_we,
    input  logic [SET_W-1:0]            lock_set,
    input  logic [WAY_W-1:0]            lock_cnt,
    input  logic [SET_W-1:0]            sel_set,
    input  logic                        advance,
    output logic [WAY_W-1:0]            victim,
    output logic [SETS-1:0][WAY_W-1:0]  lock_flat
);
    logic [SETS-1:0][WAY_W-1:0] lock_q;
    logic [SETS-1:0][WAY_W-1:0] rr_q;

    assign lock_flat = lock_q;

    // Victim is the pointer, raised to the first unlocked way if it lags behind.
    always_comb begin
        victim = (rr_q[sel_set] < lock_q[sel_set]) ? lock_q[sel_set] : rr_q[sel_set];
    end

    // Lock count writes, saturated to the cap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else if (lock_we) begin
            lock_q[lock_set] <= (int'(lock_cnt) > MAX_LOCK) ? WAY_W'(MAX_LOCK) : lock_cnt;
        end
    end

    // Pointer steps past the used victim, wrapping back to the first unlocked way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q[sel_set] <= (int'(victim) == WAYS - 1) ? lock_q[sel_set] : victim + 1'b1;
        end
    end

    assert_lock_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_we |=> (int'(lock_q[$past(lock_set)]) <= MAX_LOCK));

    assert_rr_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !lock_we) |=> (rr_q[$past(sel_set)] >= lock_q[$past(sel_set)]));
endmodule

// File: rtl/wlc_tags.sv
// Module: tag and valid arrays with a parallel compare across all ways of a set.
// Assumes: at most one way of a set holds a given tag (the controller keeps this).
module wlc_tags #(
    parameter int SETS   = 32,
    parameter int WAYS   = 32,
    parameter int TAG_W  = 22,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            look_set,
    input  logic [TAG_W-1:0]            look_tag,
    output logic                        hit,
    output logic [WAY_W-1:0]            hit_way,
    input  logic                        clr_en,
    input  logic [WAY_W-1:0]            clr_way,
    input  logic                        wr_en,
    input  logic [WAY_W-1:0]            wr_way,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic                        inval_en,
    input  logic [SETS-1:0][WAY_W-1:0]  lock_flat
);
    logic [SETS*WAYS-1:0] valid_q;
    logic [TAG_W-1:0]     tag_q [SETS*WAYS];
    logic [WAYS-1:0]      hit_vec;

    // Compare the looked-up tag with every valid way of the set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w] = valid_q[int'(look_set)*WAYS + w] &&
                         (tag_q[int'(look_set)*WAYS + w] == look_tag);
        end
    end

    // Encode the matching way (lowest index if several ever matched).
    always_comb begin
        hit     = |hit_vec;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
    end

    // Valid bits: global unlocked invalidate, victim clear, fill completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inval_en) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (w >= int'(lock_flat[s])) valid_q[s*WAYS + w] <= 1'b0;
                    end
                end
            end
            if (clr_en) valid_q[int'(look_set)*WAYS + int'(clr_way)] <= 1'b0;
            if (wr_en)  valid_q[int'(look_set)*WAYS + int'(wr_way)]  <= 1'b1;
        end
    end

    // Tag storage written on the final fill beat.
    always_ff @(posedge clk) begin
        if (wr_en) tag_q[int'(look_set)*WAYS + int'(wr_way)] <= wr_tag;
    end

    assert_single_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
endmodule

// File: rtl/wlc_lines.sv
// Module: line storage, one packed line of parity-protected words per way.
// Assumes: even parity, so the word plus its bit XOR to zero when intact.
module wlc_lines #(
    parameter int SETS    = 32,
    parameter int WAYS    = 32,
    parameter int WORDS   = 8,
    parameter int WORD_W  = 32,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int ENT_W  = WORD_W + 1,
    localparam int LINE_W = WORDS * ENT_W
) (
    input  logic              clk,
    input  logic [SET_W-1:0]  set_idx,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [OFF_W-1:0]  wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_par,
    input  logic [WAY_W-1:0]  rd_way,
    input  logic [OFF_W-1:0]  rd_word,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_ok
);
    logic [LINE_W-1:0] line_q [SETS*WAYS];
    logic [ENT_W-1:0]  rd_ent;

    // Store one fill beat with its parity bit.
    always_ff @(posedge clk) begin
        if (wr_en) line_q[int'(set_idx)*WAYS + int'(wr_way)][int'(wr_word)*ENT_W +: ENT_W] <= {wr_par, wr_data};
    end

    // Read the addressed word and check its parity.
    always_comb begin
        rd_ent  = line_q[int'(set_idx)*WAYS + int'(rd_way)][int'(rd_word)*ENT_W +: ENT_W];
        rd_data = rd_ent[WORD_W-1:0];
        rd_ok   = ~(^rd_ent);
    end
endmodule

// File: rtl/wlc_cache.sv
// Module: top of the way-lockable set-associative read-only cache controller.
// Assumes: one outstanding request; the fill source answers each fill_req with
// exactly WORDS beats in word order.
module wlc_cache #(
    parameter int ADDR_W   = 32,
    parameter int WORD_W   = 32,
    parameter int WORDS    = 8,
    parameter int SETS     = 32,
    parameter int WAYS     = 32,
    parameter int MAX_LOCK = 28,
    localparam int OFF_LSB = $clog2(WORD_W / 8),
    localparam int OFF_W   = $clog2(WORDS),
    localparam int SET_W   = $clog2(SETS),
    localparam int WAY_W   = $clog2(WAYS),
    localparam int SET_LSB = OFF_LSB + OFF_W,
    localparam int TAG_LSB = SET_LSB + SET_W,
    localparam int TAG_W   = ADDR_W - TAG_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [WAY_W-1:0]  fill_way,
    input  logic              fill_valid,
    input  logic [WORD_W-1:0] fill_data,
    input  logic              fill_par,
    output logic              par_err,
    input  logic              lock_we,
    input  logic [SET_W-1:0]  lock_set,
    input  logic [WAY_W-1:0]  lock_count,
    input  logic              inval_all
);
    import wlc_pkg::*;

    wlc_state_e                 state;
    logic [ADDR_W-1:0]          addr_q;
    logic [WAY_W-1:0]           victim_q;
    logic [OFF_W-1:0]           beat_q;
    logic [SET_W-1:0]           set_q;
    logic [TAG_W-1:0]           tag_q;
    logic [OFF_W-1:0]           off_q;
    logic                       hit, rd_ok, good_hit, last_beat, beat_wr;
    logic [WAY_W-1:0]           hit_way, rr_way, pick_way;
    logic [WORD_W-1:0]          rd_word;
    logic [SETS-1:0][WAY_W-1:0] lock_flat;

    // Address fields and control decodes.
    always_comb begin
        set_q     = addr_q[TAG_LSB-1:SET_LSB];
        tag_q     = addr_q[ADDR_W-1:TAG_LSB];
        off_q     = addr_q[SET_LSB-1:OFF_LSB];
        good_hit  = hit && rd_ok;
        pick_way  = hit ? hit_way : rr_way;
        last_beat = (beat_q == OFF_W'(WORDS - 1));
        beat_wr   = (state == ST_FILL) && fill_valid;
        req_ready = (state == ST_IDLE);
        fill_way  = victim_q;
        fill_addr = {addr_q[ADDR_W-1:SET_LSB], {SET_LSB{1'b0}}};
    end

    wlc_tags #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_set  (set_q),
        .look_tag  (tag_q),
        .hit       (hit),
        .hit_way   (hit_way),
        .clr_en    ((state == ST_LOOK) && !good_hit),
        .clr_way   (pick_way),
        .wr_en     (beat_wr && last_beat),
        .wr_way    (victim_q),
        .wr_tag    (tag_q),
        .inval_en  (inval_all && (state == ST_IDLE)),
        .lock_flat (lock_flat)
    );

    wlc_victim #(.SETS(SETS), .WAYS(WAYS), .MAX_LOCK(MAX_LOCK)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_we   (lock_we),
        .lock_set  (lock_set),
        .lock_cnt  (lock_count),
        .sel_set   (set_q),
        .advance   ((state == ST_LOOK) && !hit),
        .victim    (rr_way),
        .lock_flat (lock_flat)
    );

    wlc_lines #(.SETS(SETS), .WAYS(WAYS), .WORDS(WORDS), .WORD_W(WORD_W)) lines_i (
        .clk     (clk),
        .set_idx (set_q),
        .wr_en   (beat_wr),
        .wr_way  (victim_q),
        .wr_word (beat_q),
        .wr_data (fill_data),
        .wr_par  (fill_par),
        .rd_way  (hit_way),
        .rd_word (off_q),
        .rd_data (rd_word),
        .rd_ok   (rd_ok)
    );

    // Controller: accept, look up, respond or request a line, then count in the beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            addr_q     <= '0;
            victim_q   <= '0;
            beat_q     <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
            fill_req   <= 1'b0;
            par_err    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            fill_req   <= 1'b0;
            par_err    <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        state  <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    if (good_hit) begin
                        resp_valid <= 1'b1;
                        resp_data  <= rd_word;
                        state      <= ST_IDLE;
                    end else begin
                        fill_req <= 1'b1;
                        par_err  <= hit;
                        victim_q <= pick_way;
                        beat_q   <= '0;
                        state    <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (last_beat) state <= ST_LOOK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_fill_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |=> !fill_req);

    assert_perr_refill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> fill_req);

    assert_no_resp_in_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> !resp_valid);

    assert_resp_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready);
endmodule

// File: tb/wlc_cache_tb_top.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the way-lockable cache, one task per scenario.
module wlc_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, fill_req, par_err;
    logic [31:0] resp_data, fill_addr;
    logic [4:0]  fill_way;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_data = '0;
    logic        fill_par = 1'b0;
    logic        lock_we = 1'b0;
    logic [4:0]  lock_set = '0;
    logic [4:0]  lock_count = '0;
    logic        inval_all = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    // Scenario options used by the fill model.
    int opt_bad_beat = -1;
    int opt_gap      = -1;
    int opt_poke     = 0;
    int early_resp   = 0;

    // Results of the last access.
    int          r_fills, r_perrs, r_lat;
    logic [4:0]  r_way;
    logic [31:0] r_faddr, r_data;
    logic        r_got;

    always #2 clk = ~clk;

    wlc_cache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_way(fill_way),
        .fill_valid(fill_valid), .fill_data(fill_data), .fill_par(fill_par),
        .par_err(par_err), .lock_we(lock_we), .lock_set(lock_set),
        .lock_count(lock_count), .inval_all(inval_all)
    );

    function automatic logic [31:0] mk_addr(int tag, int set, int off);
        return (32'(tag) << 10) | (32'(set) << 5) | (32'(off) << 2);
    endfunction

    function automatic logic [31:0] mem_word(logic [31:0] line, int k);
        return {line[31:5], 3'(k), 2'b00} ^ 32'h5A3C_0F96;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Fill source: eight beats from the line address, with optional faults.
    task automatic feed(logic [31:0] line);
        for (int k = 0; k < 8; k++) begin
            if (k == opt_gap) begin
                fill_valid = 1'b0;
                @(negedge clk);
                if (resp_valid) early_resp++;
            end
            fill_valid = 1'b1;
            fill_data  = mem_word(line, k);
            fill_par   = ^mem_word(line, k) ^ (k == opt_bad_beat);
            if (opt_poke != 0 && k == 4) begin
                req_valid = 1'b1;
                req_addr  = mk_addr(99, 1, 0);
            end
            @(negedge clk);
            req_valid = 1'b0;
            if (resp_valid) early_resp++;
        end
        fill_valid   = 1'b0;
        opt_bad_beat = -1;
    endtask

    // One fetch: issue, service any fills, collect the response.
    task automatic access(logic [31:0] a);
        int c = 0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        r_fills = 0; r_perrs = 0; r_got = 1'b0; r_lat = 0; r_way = '0; r_faddr = '0; r_data = '0;
        c = 1;
        while (!r_got && c < 200) begin
            if (resp_valid) begin
                r_got  = 1'b1;
                r_data = resp_data;
                r_lat  = c;
            end else if (fill_req) begin
                r_fills++;
                if (par_err) r_perrs++;
                r_way   = fill_way;
                r_faddr = fill_addr;
                feed(fill_addr);
            end else begin
                @(negedge clk);
                c++;
            end
        end
        n_checks++;
        if (!r_got) begin
            n_fail++;
            $display("FAIL access timeout at %h: actual no response expected response", a);
        end
    endtask

    task automatic set_lock(int set, int cnt);
        @(negedge clk);
        lock_we = 1'b1; lock_set = 5'(set); lock_count = 5'(cnt);
        @(negedge clk);
        lock_we = 1'b0;
    endtask

    task automatic t_reset();
        chk("R2", "req_ready after reset", 32'(req_ready), 1);
        chk("R2", "resp_valid after reset", 32'(resp_valid), 0);
        chk("R2", "fill_req after reset", 32'(fill_req), 0);
        chk("R2", "par_err after reset", 32'(par_err), 0);
    endtask

    task automatic t_miss_hit();
        logic [31:0] a;
        int extra;
        a = mk_addr(22'h2A5, 3, 5);
        opt_gap = 3; opt_poke = 1; early_resp = 0;
        fork
            begin
                while (!fill_req) @(negedge clk);
                chk("R10", "req_ready while busy", 32'(req_ready), 0);
            end
            access(a);
        join
        opt_gap = -1; opt_poke = 0;
        chk("R2", "first access misses", 32'(r_fills), 1);
        chk("R3", "fill_addr line aligned", r_faddr, a & 32'hFFFF_FFE0);
        chk("R3", "fill_way after reset", 32'(r_way), 0);
        chk("R4", "no response during fill", 32'(early_resp), 0);
        chk("R4", "miss response data", r_data, mem_word(a, 5));
        extra = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (fill_req || resp_valid) extra++;
        end
        chk("R10", "busy request dropped", 32'(extra), 0);
        access(mk_addr(22'h2A5, 3, 2));
        chk("R5", "hit no fill", 32'(r_fills), 0);
        chk("R5", "hit latency", 32'(r_lat), 2);
        chk("R1", "hit word at offset 2", r_data, mem_word(a, 2));
        access(mk_addr(22'h2A6, 3, 5));
        chk("R1", "other tag same set misses", 32'(r_fills), 1);
        chk("R1", "other tag next way", 32'(r_way), 1);
        chk("R1", "other tag data", r_data, mem_word(mk_addr(22'h2A6, 3, 5), 5));
    endtask

    task automatic t_round_robin();
        int bad = 0;
        set_lock(7, 4);
        for (int i = 0; i < 29; i++) begin
            access(mk_addr(22'h100 + i, 7, 0));
            if (int'(r_way) != ((i < 28) ? 4 + i : 4)) bad++;
        end
        chk("R6", "victims 4..31 then wrap to 4", 32'(bad), 0);
        access(mk_addr(22'h100, 7, 1));
        chk("R6", "evicted line refetched", 32'(r_fills), 1);
        chk("R6", "next victim way 5", 32'(r_way), 5);
    endtask

    task automatic t_lock_cap();
        int bad = 0;
        set_lock(9, 31);
        for (int i = 0; i < 5; i++) begin
            access(mk_addr(22'h300 + i, 9, 0));
            if (int'(r_way) != ((i < 4) ? 28 + i : 28)) bad++;
        end
        chk("R7", "lock 31 saturates to 28", 32'(bad), 0);
    endtask

    task automatic t_parity();
        access(mk_addr(22'h77, 20, 0)); // fill with bad parity on word 3
        chk("R8", "clean word of damaged line", r_data, mem_word(mk_addr(22'h77, 20, 0), 0));
        opt_bad_beat = -1;
        access(mk_addr(22'h77, 20, 3));
        chk("R8", "par_err pulses", 32'(r_perrs), 1);
        chk("R8", "refill requested", 32'(r_fills), 1);
        chk("R8", "refill same way", 32'(r_way), 0);
        chk("R8", "corrected data", r_data, mem_word(mk_addr(22'h77, 20, 0), 3));
        access(mk_addr(22'h78, 20, 0));
        chk("R8", "pointer unmoved by refill", 32'(r_way), 1);
    endtask

    task automatic t_inval();
        for (int i = 0; i < 3; i++) access(mk_addr(22'h500 + i, 11, 0));
        set_lock(11, 2);
        @(negedge clk);
        inval_all = 1'b1;
        @(negedge clk);
        inval_all = 1'b0;
        access(mk_addr(22'h500, 11, 1));
        chk("R9", "locked way 0 kept", 32'(r_fills), 0);
        access(mk_addr(22'h501, 11, 1));
        chk("R9", "locked way 1 kept", 32'(r_fills), 0);
        access(mk_addr(22'h502, 11, 1));
        chk("R9", "unlocked way 2 dropped", 32'(r_fills), 1);
        chk("R9", "victim after invalidate", 32'(r_way), 3);
        access(mk_addr(22'h100, 7, 0));
        chk("R9", "other set unlocked dropped", 32'(r_fills), 1);
        chk("R9", "lock and pointer kept", 32'(r_way), 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_miss_hit();
        t_round_robin();
        t_lock_cap();
        opt_bad_beat = 3;
        t_parity();
        t_inval();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule